// File: doc/BRIEF.md
# Selectable-Rate Clock Enable Generator

This block runs entirely on one fixed base clock (nominally 100 MHz) and emits a one-cycle clock-enable strobe. Downstream logic stays on the same base clock and advances only on cycles where the strobe is high, so it behaves as if it ran at a lower frequency. No new clock domain and no derived clock are created.

Software picks one of four average rates by writing a 2-bit code. The design does not make the new code active straight away. It holds the code as pending and makes it active on the first base cycle where the downstream logic reports that it is idle. The strobe pattern comes from a modulo accumulator. Each cycle it adds the number of cycles to drop per window. When the sum wraps, that cycle's strobe is suppressed. This spreads the dropped cycles as evenly as the window allows. Individual strobe spacing is not uniform, and only the count per window is guaranteed.

The default window is 20 base cycles. Code 00 keeps 10 cycles (50 MHz), code 01 keeps 13 (65 MHz), code 10 keeps 16 (80 MHz) and code 11 keeps 19 (95 MHz). The port `rate_o` shows the code that is currently active.

Top module: `cen_rate_gen`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `rate_o` is 00 and `cen_o` is low. `cen_o` is high after the first clock edge following release and low after the second.
- R2: With code 00 active, any 20 consecutive cycles of the running pattern contain exactly 10 strobes, and a strobe is never followed directly by another strobe.
- R3: With code 01 active, the 20 cycles after the code is applied contain exactly 13 strobes.
- R4: With code 10 active, the 20 cycles after the code is applied contain exactly 16 strobes, and two dropped cycles are never adjacent.
- R5: With code 11 active, the 20 cycles after the code is applied contain exactly 19 strobes.
- R6: A code written while `idle_i` is low does not change `rate_o`, and it does not change the strobe count of the window in progress.
- R7: A pending code becomes `rate_o` at the first clock edge where `idle_i` is high. In the cycle after that edge `cen_o` is low, and the pattern restarts from an empty accumulator.
- R8: When several codes are written before an idle cycle, the last one written is the one applied.
- R9: `idle_i` high with no pending write leaves `rate_o` unchanged, and the running pattern keeps its per-window count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock; every flip-flop of the block uses it |
| rst_ni | input | 1 | Synchronous reset, active low |
| sel_we_i | input | 1 | Write strobe for the rate code |
| sel_code_i | input | 2 | Rate code to store as pending (00=50, 01=65, 10=80, 11=95 MHz) |
| idle_i | input | 1 | High when downstream logic can accept a rate switch |
| cen_o | output | 1 | Clock-enable strobe for downstream logic |
| rate_o | output | 2 | Rate code currently active |

## Verification
The bench uses the default parameters: a 20-cycle window and keep counts of 10, 13, 16 and 19. With these values, a single 20-cycle window shows the exact strobe count for every code. Switches happen back to back, including writes that land in the middle of a counted window and several writes queued before an idle cycle. The timing of the apply edge is checked directly: the new code must appear, and the strobe must drop, in the first sample after the idle edge.

// File: rtl/cen_rate_pkg.sv
// Package: shared types and helpers for the selectable-rate enable generator.
// Assumes a 2-bit rate code, so four selectable rates.
package cen_rate_pkg;

    localparam int SEL_W     = 2;
    localparam int NUM_RATES = 1 << SEL_W;

    typedef logic [SEL_W-1:0] rate_code_t;

    localparam rate_code_t RATE_AFTER_RESET = '0;

    // Cycles suppressed per window for a given keep count (clamped at zero).
    function automatic int unsigned drops_per_window(input int unsigned window,
                                                     input int unsigned keep);
        return (keep >= window) ? 0 : window - keep;
    endfunction

endpackage

// File: rtl/cen_sel_ctrl.sv
// Module: pending/active rate-code registers.
// A write stores a code as pending. The pending code is copied to the active
// register on the first cycle where idle_i is high; load_o flags that cycle
// so the pattern generator can restart. Assumes idle_i is in the base domain.
module cen_sel_ctrl
    import cen_rate_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  rate_code_t code_i,
    input  logic       idle_i,
    output rate_code_t active_o,
    output logic       load_o
);

    rate_code_t pend_q;
    logic       pend_v_q;
    rate_code_t active_q;

    // Apply condition: something pending and downstream idle.
    assign load_o   = pend_v_q & idle_i;
    assign active_o = active_q;

    // Pending register: latest write wins, cleared once applied.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q   <= RATE_AFTER_RESET;
            pend_v_q <= 1'b0;
        end else if (we_i) begin
            pend_q   <= code_i;
            pend_v_q <= 1'b1;
        end else if (load_o) begin
            pend_v_q <= 1'b0;
        end
    end

    // Active register: takes the pending code on the apply cycle only.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q <= RATE_AFTER_RESET;
        end else if (load_o) begin
            active_q <= pend_q;
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idle_i |=> $stable(active_q)); // R6

    AST_APPLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_v_q && idle_i) |=> (active_q == $past(pend_q))); // R7

    AST_NO_SPURIOUS_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_v_q |=> $stable(active_q)); // R9

endmodule

// File: rtl/cen_rate_table.sv
// Module: maps the active rate code to the number of cycles dropped per window.
// One entry per code is built from the KEEP_LIST parameter.
// Assumes every keep count is at most WINDOW.
module cen_rate_table
    import cen_rate_pkg::*;
#(
    parameter int unsigned WINDOW = 20,
    parameter int unsigned KEEP_LIST [NUM_RATES] = '{10, 13, 16, 19},
    localparam int SUM_W = $clog2(WINDOW) + 1
) (
    input  rate_code_t       code_i,
    output logic [SUM_W-1:0] drop_o
);

    logic [SUM_W-1:0] drop_tbl [NUM_RATES];

    // One constant table entry per selectable code.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_entry
        localparam int unsigned DROPS = drops_per_window(WINDOW, KEEP_LIST[g]);
        assign drop_tbl[g] = SUM_W'(DROPS);
    end

    // Select the entry for the active code.
    assign drop_o = drop_tbl[code_i];

endmodule

// File: rtl/cen_accum.sv
// Module: modulo accumulator that produces the enable strobe.
// Each cycle it adds drop_i modulo WINDOW. A wrap suppresses the strobe, so a
// full window holds exactly WINDOW - drop_i strobes. load_i restarts the
// pattern from zero with the strobe low. Assumes WINDOW >= 2 and drop_i <= WINDOW.
module cen_accum #(
    parameter int unsigned WINDOW = 20,
    localparam int ACC_W = $clog2(WINDOW),
    localparam int SUM_W = ACC_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [SUM_W-1:0] drop_i,
    output logic             en_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [SUM_W-1:0] sum;
    logic             wrap;
    logic             en_q;

    // Next accumulator value and wrap detection.
    always_comb begin
        sum   = {1'b0, acc_q} + drop_i;
        wrap  = (sum >= SUM_W'(WINDOW));
        acc_d = wrap ? ACC_W'(sum - SUM_W'(WINDOW)) : ACC_W'(sum);
    end

    // Accumulator and registered strobe; reset and load both restart the pattern.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || load_i) begin
            acc_q <= '0;
            en_q  <= 1'b0;
        end else begin
            acc_q <= acc_d;
            en_q  <= !wrap;
        end
    end

    assign en_o = en_q;

    AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (acc_q == '0 && !en_q)); // R7

    AST_NO_DOUBLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(drop_i) * 2 <= int'(WINDOW) && !en_q && !load_i) |=> en_q); // R4

endmodule

// File: rtl/cen_rate_gen.sv
// Module: top of the selectable-rate clock enable generator.
// It ties together the select registers, the rate table and the accumulator.
// All logic is on clk_i; cen_o is meant as a clock enable, never as a clock.
module cen_rate_gen
    import cen_rate_pkg::*;
#(
    parameter int unsigned WINDOW = 20,
    parameter int unsigned KEEP_LIST [NUM_RATES] = '{10, 13, 16, 19},
    localparam int SUM_W = $clog2(WINDOW) + 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sel_we_i,
    input  logic [1:0] sel_code_i,
    input  logic       idle_i,
    output logic       cen_o,
    output logic [1:0] rate_o
);

    rate_code_t       active;
    logic             load;
    logic [SUM_W-1:0] drop;

    // Pending/active code handling.
    cen_sel_ctrl u_sel (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (sel_we_i),
        .code_i   (sel_code_i),
        .idle_i   (idle_i),
        .active_o (active),
        .load_o   (load)
    );

    // Code to drop-count lookup.
    cen_rate_table #(
        .WINDOW    (WINDOW),
        .KEEP_LIST (KEEP_LIST)
    ) u_table (
        .code_i (active),
        .drop_o (drop)
    );

    // Strobe pattern generation.
    cen_accum #(
        .WINDOW (WINDOW)
    ) u_acc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .drop_i (drop),
        .en_o   (cen_o)
    );

    assign rate_o = active;

    AST_HALF_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_o == 2'b00 && cen_o && !load) |=> !cen_o); // R2

endmodule

// File: tb/cen_rate_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected window per applied code,
// and the monitor counts strobes over that window and compares.
module cen_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [1:0] code = 2'b00;
    logic       idle = 1'b0;
    logic       cen;
    logic [1:0] rate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit mon_busy = 1'b0;

    int    q_code [$];
    int    q_keep [$];
    string q_req  [$];

    always #2.5 clk = ~clk;

    cen_rate_gen dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sel_we_i   (we),
        .sel_code_i (code),
        .idle_i     (idle),
        .cen_o      (cen),
        .rate_o     (rate)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_monitor();
        wait (q_keep.size() == 0 && !mon_busy);
    endtask

    // Raise idle for one edge, then queue the expected window from that edge.
    task automatic pulse_idle(input int c, input int keep, input string req);
        idle = 1'b1;
        @(posedge clk);
        q_code.push_back(c);
        q_keep.push_back(keep);
        q_req.push_back(req);
        @(negedge clk);
        idle = 1'b0;
    endtask

    // Write a code, apply it at the next idle edge, and optionally write again mid-window.
    task automatic apply_rate(input logic [1:0] c, input int keep, input string req,
                              input bit mid_write);
        @(negedge clk);
        we = 1'b1; code = c; idle = 1'b0;
        @(negedge clk);
        we = 1'b0;
        pulse_idle(c, keep, req);
        if (mid_write) begin
            repeat (5) @(negedge clk);
            we = 1'b1; code = ~c;
            @(negedge clk);
            we = 1'b0;
        end
        wait_monitor();
        if (mid_write) chk(rate == c, "R6 rate held after busy write", rate, c);
    endtask

    // Monitor: apply-cycle checks, then count strobes over 20 cycles.
    initial begin
        forever begin
            int    c, keep, cnt;
            string req;
            wait (q_keep.size() > 0);
            mon_busy = 1'b1;
            c = q_code.pop_front();
            keep = q_keep.pop_front();
            req = q_req.pop_front();
            @(negedge clk);
            chk(rate == 2'(c), {req, " / R7 new code on first idle edge"}, rate, c);
            chk(cen == 1'b0, {req, " / R7 strobe low after apply"}, cen, 0);
            cnt = 0;
            repeat (20) begin
                @(negedge clk);
                cnt += int'(cen);
            end
            chk(cnt == keep, {req, " window strobe count"}, cnt, keep);
            mon_busy = 1'b0;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        repeat (4) @(negedge clk);
        chk(rate == 2'b00, "R1 rate in reset", rate, 0);
        chk(cen == 1'b0, "R1 strobe in reset", cen, 0);
        rst_n = 1'b1;
        chk(cen == 1'b0, "R1 strobe on release cycle", cen, 0);
        @(negedge clk);
        chk(cen == 1'b1, "R1 first strobe", cen, 1);
        @(negedge clk);
        chk(cen == 1'b0, "R1 second cycle dropped", cen, 0);
        chk(rate == 2'b00, "R1 rate after reset", rate, 0);

        apply_rate(2'b00, 10, "R2", 1'b0);
        apply_rate(2'b01, 13, "R3", 1'b1);
        apply_rate(2'b10, 16, "R4", 1'b0);
        apply_rate(2'b11, 19, "R5", 1'b0);

        // R8: two writes while busy; hold busy and check nothing moved (R6).
        @(negedge clk);
        we = 1'b1; code = 2'b00;
        @(negedge clk);
        code = 2'b10;
        @(negedge clk);
        we = 1'b0;
        repeat (3) @(negedge clk);
        chk(rate == 2'b11, "R6 rate held while idle low", rate, 3);
        pulse_idle(2, 16, "R8");
        wait_monitor();

        // R9: idle high without a pending write; pattern keeps its count.
        begin
            int cnt;
            idle = 1'b1;
            cnt = 0;
            repeat (20) begin
                @(negedge clk);
                cnt += int'(cen);
            end
            chk(rate == 2'b10, "R9 rate unchanged with no pending", rate, 2);
            chk(cnt == 16, "R9 running count unchanged", cnt, 16);
            idle = 1'b0;
        end

        // R2 alternation on a fresh 00 window, then a 95 MHz window again.
        apply_rate(2'b00, 10, "R2 again", 1'b0);
        begin
            int pairs;
            logic prev;
            pairs = 0;
            @(negedge clk);
            prev = cen;
            repeat (19) begin
                @(negedge clk);
                if (prev && cen) pairs++;
                prev = cen;
            end
            chk(pairs == 0, "R2 no adjacent strobes", pairs, 0);
        end
        apply_rate(2'b11, 19, "R5 again", 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule